// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds the return addresses for subroutine calls and interrupt entries of a small sequencer. A push stores the supplied 11-bit address on top of the stack. The current top entry is always driven onto the pop output, so the program counter logic can load it in the same cycle that it issues a pop strobe. The pop then removes that entry, and the entry below it appears on the output after the clock edge.

The stack is eight entries deep. It never reports overflow. When a ninth address is pushed while all eight levels are occupied, the oldest entry is silently replaced, so the stack always keeps the eight most recent addresses. Storage is a register file indexed by a top pointer that wraps modulo the depth. A separate occupancy count tells the surrounding logic how many valid entries remain. The count saturates at the depth and never goes below zero.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset is released, count_o is 0 and pop_addr_o is 0, because every entry is cleared and the top pointer starts at slot 0.
- R2: A push without a pop writes push_addr_i into the slot above the current top. In the cycle after the edge, pop_addr_o shows that address and count_o is one higher, unless count_o was already 8.
- R3: pop_addr_o combinationally shows the top entry. After a pop without a push, the pointer moves down one slot and count_o drops by one. Successive pops therefore return the pushed addresses in reverse order.
- R4: A push while count_o is 8 overwrites the oldest entry, because the pointer wraps modulo 8. count_o stays at 8, and no error is signalled. The following eight pops return the latest eight addresses, newest first.
- R5: A pop while count_o is 0 still moves the pointer down one slot, wrapping modulo 8. pop_addr_o then shows whatever that slot holds, and count_o stays 0.
- R6: A push and a pop in the same cycle replace the top entry with push_addr_i. The pointer and count_o stay unchanged.
- R7: In a cycle with neither strobe, pop_addr_o and count_o keep their values.
- R8: count_o is 4 bits wide and takes every value from 0 to 8. It never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_addr_i | input | 11 | Address to store on push |
| pop_addr_o | output | 11 | Current top-of-stack address |
| count_o | output | 4 | Number of valid entries, 0 to 8 |

## Verification
The stack is exercised with four patterns, each chosen to expose a different fault:
- **Short push-then-pop runs.** These confirm the last-in first-out ordering and the count steps of R2 and R3.
- **A twelve-deep push burst followed by eight pops.** This shows whether the pointer wraps and overwrites the oldest slots while the count holds at 8. A design that halts or flags on the ninth push returns stale addresses here.
- **Pops past empty.** These separate a pointer that keeps wrapping from one that sticks, and check that the count holds at 0.
- **Combined push-and-pop cycles and idle cycles.** These confirm that the top entry is replaced in place and that nothing drifts when no strobe is active.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_SWAP = 2'b11
  } ras_op_e;

  function automatic ras_op_e decode_op(input logic push, input logic pop);
    return ras_op_e'({push, pop});
  endfunction
endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ras_op_e          op_i,
  output logic [PTR_W-1:0] top_ptr_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d    = ptr_q;
    wr_en_o  = 1'b0;
    wr_idx_o = ptr_q;
    unique case (op_i)
      OP_PUSH: begin
        ptr_d    = ptr_q + PTR_W'(1);
        wr_en_o  = 1'b1;
        wr_idx_o = ptr_q + PTR_W'(1);
      end
      OP_POP:  ptr_d = ptr_q - PTR_W'(1);
      OP_SWAP: wr_en_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign top_ptr_o = ptr_q;

  a_r5_pop_wraps_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_POP |=> ptr_q == $past(ptr_q) - PTR_W'(1));

  a_r6_swap_holds_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SWAP |=> $stable(ptr_q));

  a_r4_push_wraps_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_PUSH |=> ptr_q == $past(ptr_q) + PTR_W'(1));
endmodule

// File: rtl/ras_count.sv
module ras_count
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ras_op_e          op_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case (op_i)
        OP_PUSH: if (cnt_q != FULL) cnt_q <= cnt_q + CNT_W'(1);
        OP_POP:  if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
        default: ;
      endcase
    end
  end

  assign count_o = cnt_q;

  a_r8_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);

  a_r4_count_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH && cnt_q == FULL) |=> cnt_q == FULL);

  a_r5_empty_pop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP && cnt_q == '0) |=> cnt_q == '0);

  a_r2_push_counts_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH && cnt_q != FULL) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  a_r6_swap_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SWAP |=> $stable(cnt_q));
endmodule

// File: rtl/ras_regfile.sv
module ras_regfile #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 11,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  logic [ADDR_W-1:0] slot_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ADDR_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                slot_q <= '0;
      else if (wr_en_i && wr_idx_i == PTR_W'(g))  slot_q <= wr_data_i;
    end
    assign slot_w[g] = slot_q;
  end

  assign rd_data_o = slot_w[rd_idx_i];

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> slot_w[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  output logic [CNT_W-1:0]  count_o
);
  ras_op_e          op;
  logic [PTR_W-1:0] top_ptr, wr_idx;
  logic             wr_en;

  assign op = decode_op(push_i, pop_i);

  ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .top_ptr_o (top_ptr),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx)
  );

  ras_count #(.DEPTH(DEPTH)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .count_o (count_o)
  );

  ras_regfile #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_addr_i),
    .rd_idx_i  (top_ptr),
    .rd_data_o (pop_addr_o)
  );

  a_r2_push_on_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> pop_addr_o == $past(push_addr_i));

  a_r6_swap_on_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> pop_addr_o == $past(push_addr_i));

  a_r7_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> ($stable(pop_addr_o) && $stable(count_o)));
endmodule

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0;
  logic        pop_i = 1'b0;
  logic [10:0] push_addr_i = '0;
  logic [10:0] pop_addr_o;
  logic [3:0]  count_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [10:0] mdl [8];
  logic [2:0]  mptr;
  int          mcnt;

  always #5 clk_i = ~clk_i;

  ret_addr_stack u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i),
    .push_addr_i(push_addr_i), .pop_addr_o(pop_addr_o), .count_o(count_o)
  );

  task automatic check_state(input string req);
    n_chk++;
    if (pop_addr_o !== mdl[mptr]) begin
      n_bad++;
      $display("FAIL %s: pop_addr_o=%h expected %h", req, pop_addr_o, mdl[mptr]);
    end
    n_chk++;
    if (count_o !== 4'(mcnt)) begin
      n_bad++;
      $display("FAIL %s: count_o=%0d expected %0d", req, count_o, mcnt);
    end
  endtask

  task automatic cycle(input logic ps, input logic pp, input logic [10:0] d,
                       input string req);
    @(negedge clk_i);
    push_i = ps; pop_i = pp; push_addr_i = d;
    @(posedge clk_i);
    #1;
    if (ps && pp) begin
      mdl[mptr] = d;
    end else if (ps) begin
      mptr = mptr + 3'd1;
      mdl[mptr] = d;
      if (mcnt < 8) mcnt++;
    end else if (pp) begin
      mptr = mptr - 3'd1;
      if (mcnt > 0) mcnt--;
    end
    check_state(req);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    mptr = '0; mcnt = 0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check_state("R1");
  endtask

  task automatic t_lifo;
    cycle(1, 0, 11'h123, "R2");
    cycle(1, 0, 11'h456, "R2");
    cycle(1, 0, 11'h7AB, "R2");
    cycle(0, 1, 11'h000, "R3");
    cycle(0, 1, 11'h000, "R3");
    cycle(0, 1, 11'h000, "R3");
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 12; i++)
      cycle(1, 0, 11'(11'h400 + i * 11'h011), (i < 8) ? "R8" : "R4");
    for (int i = 0; i < 8; i++)
      cycle(0, 1, 11'h000, "R4");
  endtask

  task automatic t_empty_pop;
    cycle(0, 1, 11'h000, "R5");
    cycle(0, 1, 11'h000, "R5");
    cycle(0, 1, 11'h000, "R5");
  endtask

  task automatic t_swap;
    cycle(1, 0, 11'h0F0, "R2");
    cycle(1, 0, 11'h0F1, "R2");
    cycle(1, 1, 11'h5A5, "R6");
    cycle(1, 1, 11'h3C3, "R6");
    cycle(0, 1, 11'h000, "R6");
    cycle(0, 1, 11'h000, "R6");
  endtask

  task automatic t_idle;
    cycle(1, 0, 11'h2B7, "R2");
    for (int i = 0; i < 3; i++)
      cycle(0, 0, 11'h7FF, "R7");
  endtask

  initial begin
    t_reset();
    t_lifo();
    t_overflow();
    t_empty_pop();
    t_swap();
    t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule